// File: doc/BRIEF.md
# Color Channel Gain/Offset Sequencer

This block decides which color channel (red, green or blue) the analog front end is digitizing at any moment, and it drives the 6-bit gain code and 8-bit offset code that belong to that channel. It runs on a fast system clock. It watches two slower inputs as plain data: the conversion clock, whose falling edges mark pixel boundaries, and the line-start input, which marks the start of a scan line. Software holds six code registers outside the block, one gain code and one offset code per color. The sequencer picks among them and registers the chosen pair. The pair then stays steady until the next channel boundary, even if the source registers change in between.

A 2-bit configuration input picks one of four modes:
- red-only (`00`);
- red input with the codes cycling per pixel (`01`);
- pixel-by-pixel rotation of input and codes (`10`), over three channels or over red and green only when `dual_ch` is set;
- line-by-line rotation (`11`), where the color advances once per new line.

In the pixel modes a high line-start level sends the channel back to red. In line mode a separate home input does this instead, because line starts are what advance the color there.

The core is a three-state machine with states CH_RED, CH_GRN and CH_BLU (codes 0, 1, 2). It has three transitions:
- advance: move to the next state, wrapping from the last active channel back to CH_RED;
- home: force CH_RED;
- hold: stay in the current state.

Top module: `chan_code_seq`

## Requirements
- R1: While reset is asserted and after its release until the first boundary event, ch_sel and in_sel are 0 (red) and gain_q and offs_q are 0.
- R2: With cfg = 00, ch_sel and in_sel stay 0 (red) across conversion-clock falling edges and line starts, and each such event loads the red gain and offset codes.
- R3: With cfg = 10 and dual_ch = 0, each conversion-clock falling edge (seen as a high sample followed by a low sample on the system clock) advances ch_sel and in_sel red(0) → green(1) → blue(2) → red(0). gain_q and offs_q take that channel's codes in the same system-clock cycle that ch_sel changes.
- R4: With cfg = 10 and dual_ch = 1, the falling edges alternate ch_sel between red(0) and green(1) only.
- R5: With cfg = 01, ch_sel and the codes cycle red → green → blue → red on falling edges, while in_sel stays red(0).
- R6: In cfg 01 and 10, a high line_start forces ch_sel to red(0). While line_start stays high, falling edges do not move the channel.
- R7: With cfg = 11, each rising edge of line_start advances ch_sel red → green → blue → red, with in_sel and codes following. Conversion-clock edges have no effect, and a line_start held high advances only once.
- R8: With cfg = 11, a high color_home forces ch_sel to red(0), and it wins over a line_start rising edge in the same cycle.
- R9: gain_q and offs_q change only on a boundary event of the current mode. A change to the gain/offset source inputs without such an event leaves the outputs unchanged, and the next event loads the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_clk | input | 1 | Conversion clock, sampled as data; falling edge marks a pixel boundary |
| line_start | input | 1 | Line-start level; resets to red in pixel modes, rising edge advances in line mode |
| color_home | input | 1 | Forces red in line-rotation mode |
| cfg | input | 2 | Signal configuration: 00 red-only, 01 code cycle, 10 pixel rotation, 11 line rotation |
| dual_ch | input | 1 | Limits pixel rotation (cfg 10) to red and green |
| gain_r | input | 6 | Red gain code |
| gain_g | input | 6 | Green gain code |
| gain_b | input | 6 | Blue gain code |
| offs_r | input | 8 | Red offset code |
| offs_g | input | 8 | Green offset code |
| offs_b | input | 8 | Blue offset code |
| ch_sel | output | 2 | Active channel: 0 red, 1 green, 2 blue |
| in_sel | output | 2 | Analog input select, same encoding |
| gain_q | output | 6 | Registered gain code of the active channel |
| offs_q | output | 8 | Registered offset code of the active channel |

## Verification
Each configuration is driven with a run of pixel edges long enough to reach the wrap point. This separates three-channel rotation from red/green alternation, and a channel index that cycles from one whose input select stays red. Line pulses are interleaved in every mode. In pixel modes they must return to red. In line mode they must step exactly one color, while pixel edges there must do nothing. Directed patterns then cover the remaining cases:
- a line_start level held across several pixel edges;
- home coinciding with a line start;
- source codes rewritten with no boundary, which tells registered capture apart from a direct pass-through.

// File: rtl/chan_code_seq_pkg.sv
package chan_code_seq_pkg;

    typedef enum logic [1:0] {
        CH_RED = 2'd0,
        CH_GRN = 2'd1,
        CH_BLU = 2'd2
    } chan_e;

    typedef enum logic [1:0] {
        MODE_RED_ONLY  = 2'd0,
        MODE_CODE_CYC  = 2'd1,
        MODE_PIXEL_ROT = 2'd2,
        MODE_LINE_ROT  = 2'd3
    } mode_e;

    // successor with wrap: anything at or past the last active channel goes red
    function automatic chan_e chan_succ(input chan_e cur, input chan_e last);
        chan_e res;
        if (cur >= last) res = CH_RED;
        else             res = chan_e'(cur + 2'd1);
        return res;
    endfunction

endpackage

// File: rtl/cgs_edge_detect.sv
module cgs_edge_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_in,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= sig_in[i];
        end
        assign rise[i] =  sig_in[i] & ~prev_q[i];
        assign fall[i] = ~sig_in[i] &  prev_q[i];
    end
endmodule

// File: rtl/cgs_chan_fsm.sv
module cgs_chan_fsm
    import chan_code_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  dual_ch,
    input  logic  pix_fall,
    input  logic  line_rise,
    input  logic  line_lvl,
    input  logic  home,
    output chan_e cur,
    output chan_e nxt,
    output logic  tick
);
    chan_e last_ch;

    assign last_ch = (mode == MODE_PIXEL_ROT && dual_ch) ? CH_GRN : CH_BLU;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= CH_RED;
        else        cur <= nxt;
    end

    // next state and boundary event
    always_comb begin
        nxt  = cur;
        tick = 1'b0;
        unique case (mode)
            MODE_RED_ONLY: begin
                nxt  = CH_RED;
                tick = pix_fall | line_lvl;
            end
            MODE_CODE_CYC, MODE_PIXEL_ROT: begin
                tick = pix_fall | line_lvl;
                if (line_lvl)      nxt = CH_RED;                   // home
                else if (pix_fall) nxt = chan_succ(cur, last_ch);  // advance
            end
            MODE_LINE_ROT: begin
                tick = line_rise | home;
                if (home)           nxt = CH_RED;                  // home
                else if (line_rise) nxt = chan_succ(cur, CH_BLU);  // advance
            end
            default: nxt = CH_RED;
        endcase
    end
endmodule

// File: rtl/cgs_code_reg.sv
module cgs_code_reg
    import chan_code_seq_pkg::*;
#(
    parameter int GAIN_W = 6,
    parameter int OFFS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  mode_e             mode,
    input  chan_e             nxt,
    input  logic [GAIN_W-1:0] gain_r,
    input  logic [GAIN_W-1:0] gain_g,
    input  logic [GAIN_W-1:0] gain_b,
    input  logic [OFFS_W-1:0] offs_r,
    input  logic [OFFS_W-1:0] offs_g,
    input  logic [OFFS_W-1:0] offs_b,
    output logic [GAIN_W-1:0] gain_q,
    output logic [OFFS_W-1:0] offs_q,
    output chan_e             in_sel
);
    logic [GAIN_W-1:0] gain_pick;
    logic [OFFS_W-1:0] offs_pick;
    chan_e             in_pick;

    always_comb begin
        unique case (nxt)
            CH_GRN:  begin gain_pick = gain_g; offs_pick = offs_g; end
            CH_BLU:  begin gain_pick = gain_b; offs_pick = offs_b; end
            default: begin gain_pick = gain_r; offs_pick = offs_r; end
        endcase
        if (mode == MODE_RED_ONLY || mode == MODE_CODE_CYC) in_pick = CH_RED;
        else                                                in_pick = nxt;
    end

    // output register: loads only on a boundary event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q <= '0;
            offs_q <= '0;
            in_sel <= CH_RED;
        end else if (tick) begin
            gain_q <= gain_pick;
            offs_q <= offs_pick;
            in_sel <= in_pick;
        end
    end
endmodule

// File: rtl/chan_code_seq.sv
module chan_code_seq
    import chan_code_seq_pkg::*;
#(
    parameter int GAIN_W = 6,
    parameter int OFFS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_clk,
    input  logic              line_start,
    input  logic              color_home,
    input  logic [1:0]        cfg,
    input  logic              dual_ch,
    input  logic [GAIN_W-1:0] gain_r,
    input  logic [GAIN_W-1:0] gain_g,
    input  logic [GAIN_W-1:0] gain_b,
    input  logic [OFFS_W-1:0] offs_r,
    input  logic [OFFS_W-1:0] offs_g,
    input  logic [OFFS_W-1:0] offs_b,
    output logic [1:0]        ch_sel,
    output logic [1:0]        in_sel,
    output logic [GAIN_W-1:0] gain_q,
    output logic [OFFS_W-1:0] offs_q
);
    localparam int EVT_N    = 2;
    localparam int IDX_CONV = 0;
    localparam int IDX_LINE = 1;

    logic [EVT_N-1:0] evt_in, evt_rise, evt_fall;
    mode_e mode;
    chan_e cur, nxt, in_ch;
    logic  tick;

    assign evt_in[IDX_CONV] = conv_clk;
    assign evt_in[IDX_LINE] = line_start;
    assign mode = mode_e'(cfg);

    cgs_edge_detect #(.N(EVT_N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (evt_in),
        .rise   (evt_rise),
        .fall   (evt_fall)
    );

    cgs_chan_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .dual_ch   (dual_ch),
        .pix_fall  (evt_fall[IDX_CONV]),
        .line_rise (evt_rise[IDX_LINE]),
        .line_lvl  (line_start),
        .home      (color_home),
        .cur       (cur),
        .nxt       (nxt),
        .tick      (tick)
    );

    cgs_code_reg #(.GAIN_W(GAIN_W), .OFFS_W(OFFS_W)) u_codes (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .mode   (mode),
        .nxt    (nxt),
        .gain_r (gain_r),
        .gain_g (gain_g),
        .gain_b (gain_b),
        .offs_r (offs_r),
        .offs_g (offs_g),
        .offs_b (offs_b),
        .gain_q (gain_q),
        .offs_q (offs_q),
        .in_sel (in_ch)
    );

    assign ch_sel = cur;
    assign in_sel = in_ch;
endmodule

// File: rtl/chan_code_seq_chk.sv
module chan_code_seq_chk #(
    parameter int GAIN_W = 6,
    parameter int OFFS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_clk,
    input logic              line_start,
    input logic              color_home,
    input logic [1:0]        cfg,
    input logic [1:0]        ch_sel,
    input logic [GAIN_W-1:0] gain_q,
    input logic [OFFS_W-1:0] offs_q
);
    logic [1:0] armed;
    logic conv_d, line_d, quiet, quiet_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed   <= 2'd0;
            conv_d  <= 1'b0;
            line_d  <= 1'b0;
            quiet_d <= 1'b0;
        end else begin
            if (armed != 2'd2) armed <= armed + 2'd1;
            conv_d  <= conv_clk;
            line_d  <= line_start;
            quiet_d <= quiet;
        end
    end

    always_comb begin
        if (cfg == 2'b11) quiet = !(line_start && !line_d) && !color_home;
        else              quiet = !(conv_d && !conv_clk) && !line_start;
    end

    assert_red_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == 2'b00) |=> (ch_sel == 2'd0));

    assert_line_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg == 2'b01 || cfg == 2'b10) && line_start) |=> (ch_sel == 2'd0));

    assert_color_home_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == 2'b11 && color_home) |=> (ch_sel == 2'd0));

    assert_step_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed == 2'd2 && ch_sel != $past(ch_sel)) |->
            (ch_sel == 2'd0 || ch_sel == $past(ch_sel) + 2'd1));

    assert_code_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed == 2'd2 && quiet_d) |-> ($stable(gain_q) && $stable(offs_q)));
endmodule

bind chan_code_seq chan_code_seq_chk #(.GAIN_W(GAIN_W), .OFFS_W(OFFS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_clk   (conv_clk),
    .line_start (line_start),
    .color_home (color_home),
    .cfg        (cfg),
    .ch_sel     (ch_sel),
    .gain_q     (gain_q),
    .offs_q     (offs_q)
);

// File: tb/chan_code_seq_tb.sv
module chan_code_seq_tb_top;
    localparam int GW = 6;
    localparam int OW = 8;
    localparam logic [1:0] A_FALL = 2'd0, A_LINE = 2'd1, A_HOME = 2'd2;
    localparam int NV = 25;
    // {cfg, dual, action, expected ch_sel, expected in_sel}
    localparam logic [8:0] VEC [NV] = '{
        {2'd2,1'b0,A_FALL,2'd1,2'd1}, {2'd2,1'b0,A_FALL,2'd2,2'd2},
        {2'd2,1'b0,A_FALL,2'd0,2'd0}, {2'd2,1'b0,A_FALL,2'd1,2'd1},
        {2'd2,1'b0,A_LINE,2'd0,2'd0},
        {2'd2,1'b1,A_FALL,2'd1,2'd1}, {2'd2,1'b1,A_FALL,2'd0,2'd0},
        {2'd2,1'b1,A_FALL,2'd1,2'd1}, {2'd2,1'b1,A_LINE,2'd0,2'd0},
        {2'd1,1'b0,A_FALL,2'd1,2'd0}, {2'd1,1'b0,A_FALL,2'd2,2'd0},
        {2'd1,1'b0,A_FALL,2'd0,2'd0}, {2'd1,1'b0,A_FALL,2'd1,2'd0},
        {2'd1,1'b0,A_LINE,2'd0,2'd0},
        {2'd0,1'b0,A_FALL,2'd0,2'd0}, {2'd0,1'b0,A_FALL,2'd0,2'd0},
        {2'd0,1'b0,A_LINE,2'd0,2'd0},
        {2'd3,1'b0,A_FALL,2'd0,2'd0}, {2'd3,1'b0,A_LINE,2'd1,2'd1},
        {2'd3,1'b0,A_FALL,2'd1,2'd1}, {2'd3,1'b0,A_LINE,2'd2,2'd2},
        {2'd3,1'b0,A_LINE,2'd0,2'd0}, {2'd3,1'b0,A_LINE,2'd1,2'd1},
        {2'd3,1'b0,A_HOME,2'd0,2'd0}, {2'd3,1'b0,A_LINE,2'd1,2'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic conv_clk = 1'b0, line_start = 1'b0, color_home = 1'b0, dual_ch = 1'b0;
    logic [1:0] cfg = 2'd0;
    logic [GW-1:0] gain_r = 6'h11, gain_g = 6'h22, gain_b = 6'h33;
    logic [OW-1:0] offs_r = 8'hA1, offs_g = 8'hB2, offs_b = 8'hC3;
    logic [1:0] ch_sel, in_sel;
    logic [GW-1:0] gain_q;
    logic [OW-1:0] offs_q;
    int runs = 0, fails = 0;

    always #2 clk = ~clk;

    chan_code_seq dut_i (
        .clk(clk), .rst_n(rst_n), .conv_clk(conv_clk), .line_start(line_start),
        .color_home(color_home), .cfg(cfg), .dual_ch(dual_ch),
        .gain_r(gain_r), .gain_g(gain_g), .gain_b(gain_b),
        .offs_r(offs_r), .offs_g(offs_g), .offs_b(offs_b),
        .ch_sel(ch_sel), .in_sel(in_sel), .gain_q(gain_q), .offs_q(offs_q)
    );

    task automatic check(input string req, input int act, input int exp);
        runs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_gain(input logic [1:0] c);
        return (c == 2'd1) ? int'(gain_g) : (c == 2'd2) ? int'(gain_b) : int'(gain_r);
    endfunction
    function automatic int exp_offs(input logic [1:0] c);
        return (c == 2'd1) ? int'(offs_g) : (c == 2'd2) ? int'(offs_b) : int'(offs_r);
    endfunction

    task automatic pix_fall();
        conv_clk = 1'b1; @(negedge clk);
        conv_clk = 1'b0; @(negedge clk);
    endtask
    task automatic line_pulse();
        line_start = 1'b1; @(negedge clk);
        line_start = 1'b0; @(negedge clk);
    endtask
    task automatic home_pulse();
        color_home = 1'b1; @(negedge clk);
        color_home = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; runs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R1 ch_sel in reset", ch_sel, 0);
        check("R1 gain_q in reset", gain_q, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 ch_sel after reset", ch_sel, 0);
        check("R1 in_sel after reset", in_sel, 0);
        check("R1 gain_q after reset", gain_q, 0);
        check("R1 offs_q after reset", offs_q, 0);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            logic [1:0] ec, ei, act;
            cfg = VEC[i][8:7]; dual_ch = VEC[i][6];
            act = VEC[i][5:4]; ec = VEC[i][3:2]; ei = VEC[i][1:0];
            if (act == A_FALL)      pix_fall();
            else if (act == A_LINE) line_pulse();
            else                    home_pulse();
            check($sformatf("R2-5/R7 vec%0d ch_sel", i), ch_sel, ec);
            check($sformatf("R5/R3 vec%0d in_sel", i), in_sel, ei);
            check($sformatf("R3 vec%0d gain_q", i), gain_q, exp_gain(ec));
            check($sformatf("R3 vec%0d offs_q", i), offs_q, exp_offs(ec));
        end

        // R8: home beats a coincident line rise (now at green, cfg 11)
        color_home = 1'b1; line_start = 1'b1; @(negedge clk);
        color_home = 1'b0; line_start = 1'b0; @(negedge clk);
        check("R8 home priority ch_sel", ch_sel, 0);

        // R7: held line_start advances only once
        line_start = 1'b1; repeat (4) @(negedge clk);
        line_start = 1'b0; @(negedge clk);
        check("R7 held line ch_sel", ch_sel, 1);
        home_pulse();

        // R6: line_start held high in pixel mode blocks advancing
        cfg = 2'd2; dual_ch = 1'b0;
        line_start = 1'b1;
        for (int k = 0; k < 4; k++) begin
            conv_clk = 1'b1; @(negedge clk);
            conv_clk = 1'b0; @(negedge clk);
            check("R6 held line ch_sel", ch_sel, 0);
        end
        line_start = 1'b0; @(negedge clk);
        pix_fall();
        check("R6 released ch_sel", ch_sel, 1);
        line_pulse();

        // R9: source change without boundary is not seen
        gain_r = 6'h05; offs_r = 8'h55;
        repeat (3) @(negedge clk);
        check("R9 gain_q hold", gain_q, 'h11);
        check("R9 offs_q hold", offs_q, 'hA1);
        line_pulse();
        check("R9 gain_q reload", gain_q, 'h05);
        check("R9 offs_q reload", offs_q, 'h55);

        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule